// File: doc/BRIEF.md
# Background Configuration Memory CRC Checker

This block scrubs a configuration memory region without any software involvement. While enabled it issues one read address per clock, walking the region from word zero to the last word and wrapping back to zero without pause. Every returned word is folded into a CRC-32 signature, so each complete walk produces a signature for the whole region.

At the end of each walk the signature is compared with a reference value. The reference is computed off-chip and written into the block once, at start-up, alongside the configuration itself. A disagreement means the stored configuration has been disturbed. The block then raises a reload request that stays up until reset, so the device can reboot from its non-volatile image.

The read port has a fixed latency set by a parameter. A matching valid pipeline inside the block lines the returned data up with the CRC update. Clearing the enable input stops new reads and holds the walk position. Reads already in flight are still absorbed, and the walk resumes where it stopped.

Top module: `cfgmem_crc_monitor`

## Requirements
- R1: While `scan_en` is high, `rd_addr` advances by one each cycle from 0 to DEPTH-1 and then wraps to 0. After reset `rd_addr` is 0.
- R2: The signature is CRC-32 with polynomial 0x04C11DB7. The register is seeded with 0xFFFFFFFF at the first word of every pass and shifts each 32-bit word in MSB first (bit 31 first). No reflection and no final XOR are applied.
- R3: `pass_done` is a one-cycle pulse. It rises exactly RD_LAT+2 cycles after the cycle in which address DEPTH-1 was presented with `scan_en` high.
- R4: `crc_bad` pulses together with `pass_done` when the pass signature differs from the stored reference. It stays low when they are equal and is never high without `pass_done`.
- R5: `reload_req` rises in the same cycle as a `crc_bad` pulse and stays high until reset, even if later passes match.
- R6: While `scan_en` is low no new address is issued and `rd_addr` holds. Reads already issued are still absorbed. Resuming continues the pass in progress, so its signature equals that of an uninterrupted pass.
- R7: A cycle with `ref_wr` high stores `ref_crc` as the reference. Every later pass comparison uses the newly stored value.
- R8: While reset is active and just after it, `pass_done`, `crc_bad` and `reload_req` are low and `rd_addr` is 0.
- R9: `rd_data` is taken as the word for the address presented exactly RD_LAT cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scan_en | input | 1 | Enables issuing reads; low freezes the walk |
| rd_addr | output | ADDR_W | Word address to the configuration memory |
| rd_data | input | 32 | Read data, valid RD_LAT cycles after its address |
| ref_wr | input | 1 | Strobe that stores `ref_crc` as the reference |
| ref_crc | input | 32 | Externally computed reference signature |
| pass_done | output | 1 | One-cycle pulse at the end of each pass |
| crc_bad | output | 1 | One-cycle pulse with `pass_done` when the signature disagrees |
| reload_req | output | 1 | Sticky reboot/reload request |

## Verification
A corrupted CRC register or a misaligned valid pipeline cannot be seen on `rd_addr`. It shows up only as a wrong `crc_bad` verdict at the next `pass_done`, which is at most DEPTH+RD_LAT+2 cycles later. A wrong walk counter shows on `rd_addr` in the very next cycle. It also moves `pass_done` off its RD_LAT+2 offset from the last address. A broken sticky latch shows as `reload_req` dropping on the first matching pass after a mismatch.

// File: rtl/cfgcrc_pkg.sv
package cfgcrc_pkg;
  localparam int          SIG_W    = 32;
  localparam logic [31:0] SIG_POLY = 32'h04C11DB7;
  localparam logic [31:0] SIG_SEED = 32'hFFFFFFFF;

  typedef struct packed {
    logic head;   // word opens a pass
    logic tail;   // word closes a pass
  } wtag_t;

  // One 32-bit word folded MSB first into the running signature
  function automatic logic [31:0] sig_fold(input logic [31:0] cur, input logic [31:0] word);
    logic [31:0] r;
    logic        fb;
    r = cur;
    for (int i = 31; i >= 0; i--) begin
      fb = r[31] ^ word[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ SIG_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/cfgcrc_rst_sync.sv
module cfgcrc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_int_n = sync_q[1];
endmodule

// File: rtl/cfgcrc_walker.sv
module cfgcrc_walker
  import cfgcrc_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int RD_LAT = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              arr_vld,
  output wtag_t             arr_tag
);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [RD_LAT-1:0] vld_q;
  wtag_t             tag_q [RD_LAT];
  wtag_t             tag_in;

  always_comb begin
    addr_d = addr_q;
    if (scan_en) addr_d = (addr_q == LAST_A) ? '0 : addr_q + 1'b1;
    tag_in.head = (addr_q == '0);
    tag_in.tail = (addr_q == LAST_A);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (scan_en) addr_q <= addr_d;
  end

  // valid/tag pipeline matching the memory read latency
  for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[0] <= 1'b0;
          tag_q[0] <= '0;
        end else begin
          vld_q[0] <= scan_en;
          tag_q[0] <= tag_in;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[s] <= 1'b0;
          tag_q[s] <= '0;
        end else begin
          vld_q[s] <= vld_q[s-1];
          tag_q[s] <= tag_q[s-1];
        end
      end
    end
  end

  assign rd_addr = addr_q;
  assign arr_vld = vld_q[RD_LAT-1];
  assign arr_tag = tag_q[RD_LAT-1];

  // R1
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && rd_addr == LAST_A) |=> (rd_addr == '0));
  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> $stable(rd_addr));
endmodule

// File: rtl/cfgcrc_engine.sv
module cfgcrc_engine
  import cfgcrc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  wtag_t       in_tag,
  input  logic [31:0] in_data,
  output logic [31:0] sig,
  output logic        sig_final
);
  logic [31:0] sig_q, sig_d;
  logic        fin_q, fin_d;

  always_comb begin
    sig_d = sig_q;
    if (in_vld) sig_d = sig_fold(in_tag.head ? SIG_SEED : sig_q, in_data);
    fin_d = in_vld & in_tag.tail;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= SIG_SEED;
      fin_q <= 1'b0;
    end else begin
      sig_q <= sig_d;
      fin_q <= fin_d;
    end
  end

  assign sig       = sig_q;
  assign sig_final = fin_q;

  // R6
  sig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(sig));
endmodule

// File: rtl/cfgcrc_judge.sv
module cfgcrc_judge (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sig_final,
  input  logic [31:0] sig,
  input  logic        ref_wr,
  input  logic [31:0] ref_crc,
  output logic        pass_done,
  output logic        crc_bad,
  output logic        reload_req
);
  logic [31:0] ref_q, ref_d;
  logic        done_q, bad_q, req_q;
  logic        done_d, bad_d, req_d;
  logic        differs;

  always_comb begin
    ref_d   = ref_wr ? ref_crc : ref_q;
    differs = (sig != ref_q);
    done_d  = sig_final;
    bad_d   = sig_final & differs;
    req_d   = req_q | (sig_final & differs);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      done_q <= 1'b0;
      bad_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      done_q <= done_d;
      bad_q  <= bad_d;
      req_q  <= req_d;
    end
  end

  assign pass_done  = done_q;
  assign crc_bad    = bad_q;
  assign reload_req = req_q;

  // R3
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_final |=> pass_done);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> !pass_done);
  // R4
  bad_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_bad |-> pass_done);
  // R5
  req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |=> reload_req);
  // R5
  req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reload_req) |-> crc_bad);
endmodule

// File: rtl/cfgmem_crc_monitor.sv
module cfgmem_crc_monitor
  import cfgcrc_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int RD_LAT = 2,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [31:0]       rd_data,
  input  logic              ref_wr,
  input  logic [31:0]       ref_crc,
  output logic              pass_done,
  output logic              crc_bad,
  output logic              reload_req
);
  logic        rst_int_n;
  logic        arr_vld;
  wtag_t       arr_tag;
  logic [31:0] sig;
  logic        sig_final;

  cfgcrc_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  cfgcrc_walker #(.DEPTH(DEPTH), .RD_LAT(RD_LAT), .ADDR_W(ADDR_W)) u_walk (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .scan_en (scan_en),
    .rd_addr (rd_addr),
    .arr_vld (arr_vld),
    .arr_tag (arr_tag)
  );

  cfgcrc_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_vld    (arr_vld),
    .in_tag    (arr_tag),
    .in_data   (rd_data),
    .sig       (sig),
    .sig_final (sig_final)
  );

  cfgcrc_judge u_judge (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sig_final  (sig_final),
    .sig        (sig),
    .ref_wr     (ref_wr),
    .ref_crc    (ref_crc),
    .pass_done  (pass_done),
    .crc_bad    (crc_bad),
    .reload_req (reload_req)
  );
endmodule

// File: tb/tb_cfgmem_crc_monitor.sv
`timescale 1ns/1ps
module tb_cfgmem_crc_monitor;
  localparam int DEPTH  = 16;
  localparam int RD_LAT = 2;
  localparam int AW     = 4;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          clk = 1'b0;
  logic          rst_n, scan_en, ref_wr;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data, ref_crc;
  logic          pass_done, crc_bad, reload_req;

  always #5 clk = ~clk;

  cfgmem_crc_monitor #(.DEPTH(DEPTH), .RD_LAT(RD_LAT)) dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .ref_wr(ref_wr), .ref_crc(ref_crc),
    .pass_done(pass_done), .crc_bad(crc_bad), .reload_req(reload_req));

  // memory model with fixed latency
  logic [31:0] mem [DEPTH];
  logic [31:0] rd_p [RD_LAT];
  always @(posedge clk) begin
    rd_p[0] <= mem[rd_addr];
    for (int k = 1; k < RD_LAT; k++) rd_p[k] <= rd_p[k-1];
  end
  assign rd_data = rd_p[RD_LAT-1];

  int n_chk = 0, n_bad = 0;
  int pass_cnt = 0;
  logic [31:0] exp_ref;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference signature from R2, bit-serial
  function automatic logic [31:0] model_sig();
    logic [31:0] r = 32'hFFFFFFFF;
    for (int w = 0; w < DEPTH; w++) begin
      logic [31:0] d = mem[w];
      for (int b = 0; b < 32; b++) begin
        logic top = r[31] ^ d[31];
        r = {r[30:0], 1'b0} ^ (top ? 32'h04C11DB7 : 32'h0);
        d = d << 1;
      end
    end
    return r;
  endfunction

  // port monitor: address walk, pass timing, verdicts
  logic [AW-1:0] exp_addr;
  longint cyc, due;
  bit exp_req, exp_bad;
  always @(negedge clk) begin
    if (!rst_n) begin
      exp_addr = '0; due = -1; cyc = 0; exp_req = 0;
    end else begin
      cyc++;
      chk(rd_addr == exp_addr, "R1", "rd_addr", 32'(rd_addr), 32'(exp_addr));
      chk(pass_done == (cyc == due), "R3", "pass_done timing", 32'(pass_done), 32'(cyc == due));
      if (pass_done) begin
        exp_bad = (model_sig() != exp_ref);
        if (exp_bad) exp_req = 1;
        chk(crc_bad == exp_bad, "R4", "crc_bad verdict (R2 signature)", 32'(crc_bad), 32'(exp_bad));
        pass_cnt++;
      end else begin
        chk(crc_bad == 1'b0, "R4", "crc_bad outside pass_done", 32'(crc_bad), 0);
      end
      chk(reload_req == exp_req, "R5", "reload_req", 32'(reload_req), 32'(exp_req));
      if (scan_en && rd_addr == LAST) due = cyc + RD_LAT + 2;
      if (scan_en) exp_addr = (exp_addr == LAST) ? '0 : exp_addr + 1'b1;
    end
  end

  task automatic do_reset();
    scan_en = 0; ref_wr = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8
    chk(rd_addr == '0, "R8", "rd_addr in reset", 32'(rd_addr), 0);
    chk(pass_done == 1'b0, "R8", "pass_done in reset", 32'(pass_done), 0);
    chk(crc_bad == 1'b0, "R8", "crc_bad in reset", 32'(crc_bad), 0);
    chk(reload_req == 1'b0, "R8", "reload_req in reset", 32'(reload_req), 0);
    @(posedge clk); #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  // R7: store a reference
  task automatic load_ref(input logic [31:0] v);
    @(posedge clk); #1 ref_wr = 1; ref_crc = v; exp_ref = v;
    @(posedge clk); #1 ref_wr = 0;
  endtask

  task automatic wait_passes(input int n, input bit rnd_en);
    int target = pass_cnt + n;
    while (pass_cnt < target) begin
      @(posedge clk); #1;
      if (rnd_en) scan_en = (($urandom % 10) < 7);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    ref_crc = '0; exp_ref = '0;
    for (int i = 0; i < DEPTH; i++) mem[i] = $urandom;

    // R8, then R1/R2/R3/R9 with continuous enable
    do_reset();
    load_ref(model_sig());
    scan_en = 1;
    wait_passes(2, 0);

    // R7/R4/R5: wrong reference gives mismatch and sticky request
    load_ref(model_sig() ^ 32'h0000_0001);
    wait_passes(2, 0);
    load_ref(model_sig());
    wait_passes(2, 0);
    // R5 sticky after matching passes
    @(negedge clk);
    chk(reload_req == 1'b1, "R5", "reload_req stays set", 32'(reload_req), 1);

    // R2 directed: all-zero region
    do_reset();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    load_ref(model_sig());
    scan_en = 1;
    wait_passes(2, 0);

    // R2 directed: all-ones region
    do_reset();
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
    load_ref(model_sig());
    scan_en = 1;
    wait_passes(1, 0);

    // R6: stall mid-pass, then random enable
    do_reset();
    for (int i = 0; i < DEPTH; i++) mem[i] = $urandom;
    load_ref(model_sig());
    scan_en = 1;
    repeat (7) @(posedge clk);
    #1 scan_en = 0;
    repeat (25) @(posedge clk);
    #1 scan_en = 1;
    wait_passes(1, 0);
    wait_passes(4, 1);

    // upset in the last word after a pass ends: next pass mismatches (R4, R5)
    mem[DEPTH-1] = mem[DEPTH-1] ^ 32'h0010_0000;
    wait_passes(2, 1);
    @(negedge clk);
    chk(reload_req == 1'b1, "R5", "reload_req after upset", 32'(reload_req), 1);

    scan_en = 0;
    repeat (8) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule